// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block forms the effective address for a memory access made through a pointer register, and keeps that pointer inside a circular buffer. Each request carries the current pointer value, a signed step, an addressing-mode code, and two flags that describe the access path. The block adds the step to the pointer. If modulo mode is on and the sum has left the buffer window, it folds the sum back by one buffer length. It then returns the address to use for the access and, where the mode calls for it, a new pointer value with a write enable for the register file.

The buffer is described by an inclusive start address, an inclusive end address and a direction bit. A single-cycle configuration strobe loads these together with the modulo enable. The boundary test compares magnitudes, not equality. A pointer that steps past the boundary by more than one word is therefore folded correctly, as long as the step is no larger than the buffer length.

When bit-reversed addressing is active on a write access, modulo correction is bypassed for that access. Read accesses are still corrected. All outputs are registered, one cycle after the request.

Top module: `mod_addr_unit`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `out_valid` and `out_wb_en` are 0 and `out_ea` and `out_wb_data` are 0.
- R2: For an incrementing buffer (`cfg_up`=1) with modulo correction active, a sum `ptr+step` greater than the end address is reduced by the length (end − start + 1).
- R3: For a decrementing buffer (`cfg_up`=0) with modulo correction active, a sum `ptr+step` below the start address is increased by the length.
- R4: A sum equal to the end address (incrementing) or to the start address (decrementing) is not corrected. A step of up to one buffer length that overshoots a boundary by several words still yields the folded address inside the window.
- R5: Mode code 2'b00 (post-modify): `out_ea` is the unmodified pointer, `out_wb_data` is the corrected sum, and `out_wb_en` is 1.
- R6: Mode code 2'b01 (pre-modify): both `out_ea` and `out_wb_data` are the corrected sum, and `out_wb_en` is 1.
- R7: Mode code 2'b10 (register plus offset): `out_ea` is the corrected sum, `out_wb_en` is 0, and `out_wb_data` returns the unchanged pointer.
- R8: Mode code 2'b11 (plain indirect): `out_ea` and `out_wb_data` are the pointer, and `out_wb_en` is 0.
- R9: With modulo disabled (`cfg_en`=0), the sum is plain binary arithmetic modulo 2^AW, with no correction.
- R10: When `req_bitrev` and `req_wr_path` are both 1, no correction is applied. With `req_bitrev`=1 on a read (`req_wr_path`=0), correction still applies.
- R11: The outputs appear one clock after the request. `out_valid` equals the previous cycle's `req_valid`, and `out_wb_en` is 0 whenever `out_valid` is 0.
- R12: A configuration written with `cfg_we` applies to requests from the next cycle on. A request in the same cycle as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the buffer settings below |
| cfg_start | input | AW | Inclusive lower buffer address |
| cfg_end | input | AW | Inclusive upper buffer address |
| cfg_up | input | 1 | 1 = incrementing buffer, 0 = decrementing |
| cfg_en | input | 1 | Modulo correction enable |
| req_valid | input | 1 | Request present |
| req_ptr | input | AW | Current pointer register value |
| req_step | input | SW | Signed step or offset (two's complement) |
| req_mode | input | 2 | 00 post-modify, 01 pre-modify, 10 reg+offset, 11 plain indirect |
| req_wr_path | input | 1 | Access is on the write path |
| req_bitrev | input | 1 | Bit-reversed addressing active for this pointer |
| out_valid | output | 1 | Result present |
| out_ea | output | AW | Effective address |
| out_wb_en | output | 1 | Write new pointer value back |
| out_wb_data | output | AW | Pointer write-back value |

## Verification
Single-word, two-word and multi-word steps are applied in both directions, starting from pointers close to each boundary. These separate a magnitude compare from an equality compare, and show whether landing exactly on a boundary is wrongly folded. The same sums are then sent under all four mode codes, which shows which of address and write-back gets the corrected value. Runs with modulo disabled, and with the bit-reversed flag on the write path and then on the read path, show that correction switches off only where it should. Buffers at the bottom and top of the address space check that sums below zero or above 2^AW−1 are compared at full width before truncation. A swept sequence that writes the configuration in the same cycle as requests checks the timing of setting updates.

// File: rtl/maddr_pkg.sv
package maddr_pkg;
  typedef enum logic [1:0] {
    AM_POST   = 2'b00,
    AM_PRE    = 2'b01,
    AM_OFFS   = 2'b10,
    AM_DIRECT = 2'b11
  } am_mode_e;
endpackage

// File: rtl/mod_cfg_regs.sv
module mod_cfg_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic          cfg_up,
  input  logic          cfg_en,
  output logic [AW-1:0] lo_q,
  output logic [AW-1:0] hi_q,
  output logic          up_q,
  output logic          en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
      up_q <= 1'b1;
      en_q <= 1'b0;
    end else if (cfg_we) begin
      lo_q <= cfg_start;
      hi_q <= cfg_end;
      up_q <= cfg_up;
      en_q <= cfg_en;
    end
  end
endmodule

// File: rtl/mod_wrap.sv
module mod_wrap #(
  parameter int AW = 16,
  parameter int SW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          up,
  input  logic          active,
  output logic [AW-1:0] fixed
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] base_x, step_x, sum_x, lo_x, hi_x, len_x, fix_x;
  logic over_hi, under_lo;

  always_comb begin
    base_x   = signed'({2'b00, base});
    step_x   = signed'({{(EW-SW){step[SW-1]}}, step});
    lo_x     = signed'({2'b00, lo});
    hi_x     = signed'({2'b00, hi});
    len_x    = hi_x - lo_x + EW'(1);
    sum_x    = base_x + step_x;
    over_hi  = up && (sum_x > hi_x);
    under_lo = !up && (sum_x < lo_x);
    if (active && over_hi)       fix_x = sum_x - len_x;
    else if (active && under_lo) fix_x = sum_x + len_x;
    else                         fix_x = sum_x;
    fixed = fix_x[AW-1:0];
  end
endmodule

// File: rtl/mod_addr_unit.sv
module mod_addr_unit
  import maddr_pkg::*;
#(
  parameter int AW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic          cfg_up,
  input  logic          cfg_en,
  input  logic          req_valid,
  input  logic [AW-1:0] req_ptr,
  input  logic [SW-1:0] req_step,
  input  logic [1:0]    req_mode,
  input  logic          req_wr_path,
  input  logic          req_bitrev,
  output logic          out_valid,
  output logic [AW-1:0] out_ea,
  output logic          out_wb_en,
  output logic [AW-1:0] out_wb_data
);
  logic [AW-1:0] lo_q, hi_q, fixed, ea_d, wb_d;
  logic          up_q, en_q, active, wbe_d;
  am_mode_e      mode;

  mod_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_start(cfg_start),
    .cfg_end(cfg_end), .cfg_up(cfg_up), .cfg_en(cfg_en),
    .lo_q(lo_q), .hi_q(hi_q), .up_q(up_q), .en_q(en_q)
  );

  // write-path bit reversal takes priority over modulo correction
  assign active = en_q && !(req_wr_path && req_bitrev);

  mod_wrap #(.AW(AW), .SW(SW)) u_wrap (
    .base(req_ptr), .step(req_step), .lo(lo_q), .hi(hi_q),
    .up(up_q), .active(active), .fixed(fixed)
  );

  always_comb begin
    mode = am_mode_e'(req_mode);
    case (mode)
      AM_POST:   begin ea_d = req_ptr; wb_d = fixed;   wbe_d = 1'b1; end
      AM_PRE:    begin ea_d = fixed;   wb_d = fixed;   wbe_d = 1'b1; end
      AM_OFFS:   begin ea_d = fixed;   wb_d = req_ptr; wbe_d = 1'b0; end
      default:   begin ea_d = req_ptr; wb_d = req_ptr; wbe_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_ea      <= '0;
      out_wb_en   <= 1'b0;
      out_wb_data <= '0;
    end else begin
      out_valid   <= req_valid;
      out_ea      <= ea_d;
      out_wb_en   <= req_valid && wbe_d;
      out_wb_data <= wb_d;
    end
  end

  // ---------------- assertions ----------------
  logic [AW:0] span_w, mag_up, mag_dn;
  logic        in_win;
  assign span_w = {1'b0, hi_q} - {1'b0, lo_q} + (AW+1)'(1);
  assign mag_up = (AW+1)'(req_step);
  assign mag_dn = (AW+1)'(~req_step + SW'(1));
  assign in_win = (hi_q >= lo_q) && (req_ptr >= lo_q) && (req_ptr <= hi_q);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  a_r11_idle_no_wb: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !out_wb_en));
  a_r5_post_ea: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b00) |=> (out_wb_en && out_ea == $past(req_ptr)));
  a_r6_pre_same: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b01) |=> (out_wb_en && out_ea == out_wb_data));
  a_r7_offs_keep: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b10) |=> (!out_wb_en && out_wb_data == $past(req_ptr)));
  a_r8_direct: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b11) |=> (!out_wb_en && out_ea == $past(req_ptr)));
  a_r2_up_in_window: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b01 && active && up_q && in_win &&
     !req_step[SW-1] && mag_up <= span_w)
    |=> (out_ea >= $past(lo_q) && out_ea <= $past(hi_q)));
  a_r3_dn_in_window: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b01 && active && !up_q && in_win &&
     req_step[SW-1] && mag_dn <= span_w)
    |=> (out_ea >= $past(lo_q) && out_ea <= $past(hi_q)));
  a_r9_plain_sum: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b01 && !en_q)
    |=> (out_ea == $past(req_ptr + AW'(req_step))));
endmodule

// File: tb/tb_mod_addr_unit.sv
`timescale 1ns/1ps
module tb_mod_addr_unit;
  localparam int AW = 16;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_up = 1, cfg_en = 0;
  logic [AW-1:0] cfg_start = '0, cfg_end = '0;
  logic req_valid = 0, req_wr_path = 0, req_bitrev = 0;
  logic [AW-1:0] req_ptr = '0;
  logic [SW-1:0] req_step = '0;
  logic [1:0] req_mode = '0;
  logic out_valid, out_wb_en;
  logic [AW-1:0] out_ea, out_wb_data;

  always #2.5 clk = ~clk;

  mod_addr_unit #(.AW(AW), .SW(SW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_start(cfg_start),
    .cfg_end(cfg_end), .cfg_up(cfg_up), .cfg_en(cfg_en),
    .req_valid(req_valid), .req_ptr(req_ptr), .req_step(req_step),
    .req_mode(req_mode), .req_wr_path(req_wr_path), .req_bitrev(req_bitrev),
    .out_valid(out_valid), .out_ea(out_ea), .out_wb_en(out_wb_en),
    .out_wb_data(out_wb_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  // bench copy of the buffer settings
  int b_start = 0, b_end = 0;
  bit b_up = 1, b_en = 0;
  // expectation for the next sampled cycle
  bit e_valid = 0, e_wbe = 0;
  int e_ea = 0, e_wb = 0;
  string e_tag = "R1";

  task automatic compare();
    checks++;
    if (out_valid !== e_valid || out_wb_en !== e_wbe ||
        (e_valid && (out_ea !== AW'(e_ea) || out_wb_data !== AW'(e_wb)))) begin
      fails++;
      $display("FAIL %s: valid=%0b wbe=%0b ea=%h wb=%h expected valid=%0b wbe=%0b ea=%h wb=%h",
               e_tag, out_valid, out_wb_en, out_ea, out_wb_data,
               e_valid, e_wbe, e_ea[AW-1:0], e_wb[AW-1:0]);
    end
  endtask

  task automatic idle(string tag);
    @(negedge clk); compare();
    req_valid = 0; cfg_we = 0;
    e_valid = 0; e_wbe = 0; e_tag = tag;
  endtask

  // R12: bench settings change only after the current request is modelled
  task automatic cfg(int s, int e, bit up, bit en, string tag);
    @(negedge clk); compare();
    req_valid = 0; cfg_we = 1;
    cfg_start = AW'(s); cfg_end = AW'(e); cfg_up = up; cfg_en = en;
    e_valid = 0; e_wbe = 0; e_tag = tag;
    b_start = s; b_end = e; b_up = up; b_en = en;
  endtask

  task automatic req(int ptr, int step, int mode, bit wr, bit br, string tag,
                     bit with_cfg = 0, int ns = 0, int ne = 0, bit nup = 1, bit nen = 1);
    int m;
    @(negedge clk); compare();
    req_valid = 1; req_ptr = AW'(ptr); req_step = SW'(step);
    req_mode = 2'(mode); req_wr_path = wr; req_bitrev = br;
    cfg_we = with_cfg;
    cfg_start = AW'(ns); cfg_end = AW'(ne); cfg_up = nup; cfg_en = nen;
    m = ptr + step;
    if (b_en && !(wr && br)) begin
      if (b_up && m > b_end) m = m - (b_end - b_start + 1);
      else if (!b_up && m < b_start) m = m + (b_end - b_start + 1);
    end
    m = m & ((1 << AW) - 1);
    case (mode)
      0: begin e_ea = ptr; e_wb = m;   e_wbe = 1; end
      1: begin e_ea = m;   e_wb = m;   e_wbe = 1; end
      2: begin e_ea = m;   e_wb = ptr; e_wbe = 0; end
      default: begin e_ea = ptr; e_wb = ptr; e_wbe = 0; end
    endcase
    e_valid = 1; e_tag = tag;
    if (with_cfg) begin b_start = ns; b_end = ne; b_up = nup; b_en = nen; end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    compare();
    rst = 0;
    idle("R1");

    // incrementing buffer 0x1000..0x101F
    cfg(32'h1000, 32'h101F, 1, 1, "R12");
    idle("R12");
    req(32'h101E, 1, 1, 0, 0, "R4");   // lands on end: no fold
    req(32'h101F, 1, 1, 0, 0, "R2");   // step 1 past end
    req(32'h101E, 2, 1, 0, 0, "R2");   // step 2 past end
    req(32'h1018, 16, 1, 0, 0, "R4");  // larger than remaining
    req(32'h1000, 32, 1, 0, 0, "R4");  // full length step
    req(32'h101F, 3, 0, 0, 0, "R5");
    req(32'h101F, 3, 1, 0, 0, "R6");
    req(32'h101F, 3, 2, 0, 0, "R7");
    req(32'h101F, 3, 3, 0, 0, "R8");
    req(32'h101E, 4, 1, 1, 1, "R10");  // write + bitrev: no fold
    req(32'h101E, 4, 1, 0, 1, "R10");  // read + bitrev: fold
    req(32'h101E, 4, 1, 1, 0, "R10");
    idle("R11");
    idle("R11");

    // decrementing buffer
    cfg(32'h1000, 32'h101F, 0, 1, "R12");
    req(32'h1001, -1, 1, 0, 0, "R4");  // lands on start: no fold
    req(32'h1000, -1, 1, 0, 0, "R3");
    req(32'h1001, -2, 1, 0, 0, "R3");
    req(32'h1004, -10, 1, 0, 0, "R4");
    req(32'h101F, -32, 1, 0, 0, "R4");
    req(32'h1000, -2, 0, 0, 0, "R5");
    req(32'h1000, -2, 2, 0, 0, "R7");
    req(32'h1000, -2, 1, 1, 1, "R10");

    // buffer at bottom of space, sum below zero
    cfg(0, 32'h1F, 0, 1, "R3");
    req(0, -2, 1, 0, 0, "R3");
    // buffer at top of space, sum above 2^AW-1
    cfg(32'hFFE0, 32'hFFFF, 1, 1, "R2");
    req(32'hFFFE, 4, 1, 0, 0, "R2");
    req(32'hFFFE, 4, 0, 0, 0, "R5");

    // modulo disabled
    cfg(32'h1000, 32'h101F, 1, 0, "R9");
    req(32'h101F, 3, 1, 0, 0, "R9");
    req(32'hFFFF, 2, 1, 0, 0, "R9");
    req(0, -1, 0, 0, 0, "R9");

    // R12: config written in same cycle as request; request uses old settings
    req(32'h101F, 1, 1, 0, 0, "R12", 1, 32'h1000, 32'h101F, 1, 1);
    req(32'h101F, 1, 1, 0, 0, "R12");

    // sweep across modes, directions and step sizes
    for (int i = 0; i < 400; i++) begin
      int len, st, p, s;
      len = 8 + (i % 5) * 6;
      st  = 32'h2000 + (i % 3) * 4;
      if (i % 50 == 0)
        cfg(st, st + len - 1, (i / 50) % 2 == 0, 1, "R4");
      else begin
        len = b_end - b_start + 1;
        p = b_start + (i * 7) % len;
        s = (i * 13) % (len + 1);
        if (!b_up) s = -s;
        req(p, s, i % 4, (i % 6) == 0, (i % 5) == 0, "R4");
      end
    end
    idle("R11");
    idle("R11");
    @(negedge clk); compare();
    done = 1;
    summary();
    $finish;
  end
endmodule